// File: doc/BRIEF.md
# Self-Framing Serial Register Write Port

This block turns a one-wire serial stream into register write requests without any frame-sync input. It watches the serial data line on each falling edge of the serial clock. While idle, a high bit marks the start of a frame. A fixed run of don't-care bits follows that start bit and is skipped. An address field and then a data byte are shifted in, each most significant bit first.

When the last data bit arrives, the address and data are presented together with a one-cycle write strobe, ready for a downstream arbiter. Because the start bit is what opens a frame, a host that sends 16-bit words can lead each word with one low bit. That low bit is simply seen as idle, and the frame bit then lands in the second position of the word.

The default frame is 15 bits long: the start bit, 3 ignored bits, a 3-bit address and an 8-bit data byte. The gap length and both field widths are parameters.

Top module: `sfs_wr_port`

## Requirements
- R1: `sdi` is sampled only on the falling edge of `sclk`. A level that `sdi` holds only while `sclk` is low does not reach the outputs.
- R2: While idle, a falling edge that samples `sdi` high starts a frame. Idle edges that sample `sdi` low start nothing and produce no strobe. This includes the leading low bit of a 16-bit host word.
- R3: The GAP_BITS edges after the start bit (3 by default) are ignored. Their values have no effect on the captured address or data.
- R4: The next ADDR_W edges capture `wr_addr` and the DATA_W edges after them capture `wr_data`, each field most significant bit first. The default frame is therefore start, 3 ignored bits, A2..A0, D7..D0.
- R5: `wr_stb` is high for exactly one `sclk` cycle. It is updated on the falling edge that samples the last data bit, and `wr_addr`/`wr_data` carry the new word in that same cycle. `wr_addr` and `wr_data` hold that word until the next strobe.
- R6: Once a frame has started, high bits on `sdi` are payload and never restart framing.
- R7: After the last data bit the port is idle again. A start bit on the very next falling edge opens a new frame, so frames may run back to back with no gap.
- R8: A high `rst`, sampled on a falling edge of `sclk`, abandons any partial frame and returns the port to idle. It clears the shifter and drives `wr_stb`, `wr_addr` and `wr_data` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial data line carrying the self-framed words |
| wr_stb | output | 1 | One-cycle write request strobe |
| wr_addr | output | ADDR_W | Register address of the latest write |
| wr_data | output | DATA_W | Data byte of the latest write |

## Verification
The bench builds the port with its defaults: a 3-bit gap, a 3-bit address and an 8-bit data field. This gives a 15-bit frame, so every address value and the all-ones and all-zeros bytes can each be driven in a handful of frames. With that short frame the bench can also run back-to-back frames, all-high gap and payload runs, and a reset that lands in the middle of a frame. One frame carries data that is valid only around the falling edge and inverted while the clock is low, which separates falling-edge sampling from any other sampling point.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GAP   = 2'd1,
    ST_SHIFT = 2'd2
  } sfs_state_e;
endpackage

// File: rtl/sfs_frame_seq.sv
module sfs_frame_seq
  import sfs_pkg::*;
#(
  parameter int GAP_BITS = 3,
  parameter int PAY_W    = 11
) (
  input  logic sclk,
  input  logic rst,
  input  logic sdi,
  output logic shift_en,
  output logic last_bit
);
  localparam int MAXC = (GAP_BITS > PAY_W) ? GAP_BITS : PAY_W;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] GAP_LAST = (GAP_BITS > 0) ? CW'(GAP_BITS - 1) : '0;
  localparam logic [CW-1:0] PAY_LAST = CW'(PAY_W - 1);

  sfs_state_e      state;
  logic [CW-1:0]   cnt;

  generate
    if (GAP_BITS > 0) begin : g_gap
      always_ff @(negedge sclk) begin
        if (rst) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else begin
          case (state)
            ST_IDLE: begin
              cnt <= '0;
              if (sdi) state <= ST_GAP;
            end
            ST_GAP: begin
              if (cnt == GAP_LAST) begin
                state <= ST_SHIFT;
                cnt   <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            ST_SHIFT: begin
              if (cnt == PAY_LAST) begin
                state <= ST_IDLE;
                cnt   <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: begin
              state <= ST_IDLE;
              cnt   <= '0;
            end
          endcase
        end
      end
    end else begin : g_nogap
      always_ff @(negedge sclk) begin
        if (rst) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else begin
          case (state)
            ST_IDLE: begin
              cnt <= '0;
              if (sdi) state <= ST_SHIFT;
            end
            ST_SHIFT: begin
              if (cnt == PAY_LAST) begin
                state <= ST_IDLE;
                cnt   <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: begin
              state <= ST_IDLE;
              cnt   <= '0;
            end
          endcase
        end
      end
    end
  endgenerate

  always_comb begin
    shift_en = (state == ST_SHIFT);
    last_bit = (state == ST_SHIFT) && (cnt == PAY_LAST);
  end

  // R2: an idle high bit opens a frame
  assert_frame_start_R2: assert property (@(negedge sclk) disable iff (rst)
    (state == ST_IDLE && sdi) |=> (state != ST_IDLE));

  // R3: the gap counter never runs past the gap length
  assert_gap_bound_R3: assert property (@(negedge sclk) disable iff (rst)
    (state == ST_GAP) |-> (int'(cnt) < GAP_BITS));

  // R6: mid-payload bits never reopen framing
  assert_no_restart_R6: assert property (@(negedge sclk) disable iff (rst)
    (state == ST_SHIFT && !last_bit) |=> (state == ST_SHIFT));

  // R7: the port is idle right after the last data bit
  assert_idle_after_last_R7: assert property (@(negedge sclk) disable iff (rst)
    last_bit |=> (state == ST_IDLE));
endmodule

// File: rtl/sfs_shifter.sv
module sfs_shifter #(
  parameter int PAY_W = 11
) (
  input  logic             sclk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             sdi,
  output logic [PAY_W-2:0] held
);
  generate
    if (PAY_W > 2) begin : g_wide
      always_ff @(negedge sclk) begin
        if (rst)           held <= '0;
        else if (shift_en) held <= {held[PAY_W-3:0], sdi};
      end
    end else begin : g_narrow
      always_ff @(negedge sclk) begin
        if (rst)           held <= '0;
        else if (shift_en) held <= sdi;
      end
    end
  endgenerate
endmodule

// File: rtl/sfs_out_reg.sv
module sfs_out_reg #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                      sclk,
  input  logic                      rst,
  input  logic                      capture,
  input  logic [ADDR_W+DATA_W-1:0]  word,
  output logic                      wr_stb,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [DATA_W-1:0]         wr_data
);
  always_ff @(negedge sclk) begin
    if (rst) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= capture;
      if (capture) begin
        wr_addr <= word[ADDR_W+DATA_W-1:DATA_W];
        wr_data <= word[DATA_W-1:0];
      end
    end
  end

  // R5: the strobe never lasts two cycles
  assert_single_pulse_R5: assert property (@(negedge sclk) disable iff (rst)
    wr_stb |=> !wr_stb);

  // R5: the presented word holds between strobes
  assert_word_hold_R5: assert property (@(negedge sclk) disable iff (rst)
    !capture |=> ($stable(wr_addr) && $stable(wr_data)));
endmodule

// File: rtl/sfs_wr_port.sv
module sfs_wr_port #(
  parameter int GAP_BITS = 3,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8
) (
  input  logic              sclk,
  input  logic              rst,
  input  logic              sdi,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int PAY_W = ADDR_W + DATA_W;

  logic             shift_en;
  logic             last_bit;
  logic [PAY_W-2:0] held;
  logic [PAY_W-1:0] word;

  sfs_frame_seq #(.GAP_BITS(GAP_BITS), .PAY_W(PAY_W)) seq_i (
    .sclk(sclk), .rst(rst), .sdi(sdi),
    .shift_en(shift_en), .last_bit(last_bit)
  );

  sfs_shifter #(.PAY_W(PAY_W)) shf_i (
    .sclk(sclk), .rst(rst), .shift_en(shift_en), .sdi(sdi), .held(held)
  );

  assign word = {held, sdi};

  sfs_out_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) out_i (
    .sclk(sclk), .rst(rst), .capture(last_bit), .word(word),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: tb/sfs_wr_port_tb_top.sv
`timescale 1ns/1ps
module sfs_wr_port_tb_top;
  logic       sclk = 1'b0;
  logic       rst  = 1'b1;
  logic       sdi  = 1'b0;
  logic       wr_stb;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    logic [2:0] a;
    logic [7:0] d;
    int         c;
  } exp_t;
  exp_t exp_q[$];

  logic [2:0] last_a = '0;
  logic [7:0] last_d = '0;
  bit         prev_stb = 0;
  int         strobes = 0;

  always #5 sclk = ~sclk;

  sfs_wr_port dut_i (
    .sclk(sclk), .rst(rst), .sdi(sdi),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Monitor: outputs change on the falling edge, sampled on the rising edge
  always @(posedge sclk) begin
    cyc = cyc + 1;
    if (rst) begin
      last_a   = '0;
      last_d   = '0;
      prev_stb = 0;
    end else begin
      if (wr_stb) begin
        strobes++;
        checks++;
        if (prev_stb) begin
          errors++;
          $display("FAIL R5 strobe wider than one cycle: got 1 expected 0 at cycle %0d", cyc);
        end
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected strobe: got addr %0h data %0h expected none", wr_addr, wr_data);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          checks++;
          if (wr_addr !== e.a || wr_data !== e.d) begin
            errors++;
            $display("FAIL R4 word: got addr %0h data %0h expected addr %0h data %0h",
                     wr_addr, wr_data, e.a, e.d);
          end
          checks++;
          if (cyc != e.c) begin
            errors++;
            $display("FAIL R5 strobe cycle: got %0d expected %0d", cyc, e.c);
          end
        end
        last_a = wr_addr;
        last_d = wr_data;
      end else begin
        checks++;
        if (wr_addr !== last_a || wr_data !== last_d) begin
          errors++;
          $display("FAIL R5 hold: got addr %0h data %0h expected addr %0h data %0h",
                   wr_addr, wr_data, last_a, last_d);
        end
      end
      prev_stb = wr_stb;
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge sclk); #1;
      sdi = 1'b0;
    end
  endtask

  // Driver: gapv fills the ignored bits (R3); noisy inverts sdi while sclk is low (R1)
  task automatic send_frame(input logic [2:0] a, input logic [7:0] d,
                            input logic gapv, input bit noisy);
    logic [14:0] w;
    exp_t e;
    w = {1'b1, {3{gapv}}, a, d};
    for (int i = 14; i >= 0; i--) begin
      @(posedge sclk); #1;
      sdi = w[i];
      if (i == 0) begin
        e.a = a; e.d = d; e.c = cyc + 1;
        exp_q.push_back(e);
      end
      if (noisy) begin
        @(negedge sclk); #1;
        sdi = ~w[i];
      end
    end
  endtask

  task automatic check_zero(input string tag);
    checks++;
    if (wr_stb !== 1'b0 || wr_addr !== '0 || wr_data !== '0) begin
      errors++;
      $display("FAIL %s reset outputs: got stb %b addr %0h data %0h expected 0 0 0",
               tag, wr_stb, wr_addr, wr_data);
    end
  endtask

  initial begin
    int s0;
    repeat (3) @(posedge sclk);
    #1;
    check_zero("R8");
    rst = 1'b0;

    // R2: long idle low run, plus a leading low bit before each word
    s0 = strobes;
    idle(20);
    checks++;
    if (strobes != s0) begin
      errors++;
      $display("FAIL R2 idle strobes: got %0d expected %0d", strobes - s0, 0);
    end

    // R4: plain frames, each field MSB first
    idle(1); send_frame(3'h5, 8'hA3, 1'b0, 0);
    idle(1); send_frame(3'h2, 8'h01, 1'b0, 0);
    idle(4);
    // R3: all-high ignored bits
    send_frame(3'h0, 8'h80, 1'b1, 0);
    idle(3);
    // R6: all-high payload followed by zeros, no restart
    send_frame(3'h7, 8'hFF, 1'b1, 0);
    idle(15);
    // R7: back-to-back frames with no idle bit between
    send_frame(3'h1, 8'h5A, 1'b0, 0);
    send_frame(3'h6, 8'hC3, 1'b1, 0);
    send_frame(3'h3, 8'h00, 1'b0, 0);
    idle(5);
    // R1: data valid only around the falling edge
    send_frame(3'h4, 8'h96, 1'b0, 1);
    idle(5);

    // R8: reset in mid-frame abandons it
    @(posedge sclk); #1; sdi = 1'b1;
    repeat (6) begin @(posedge sclk); #1; sdi = 1'b1; end
    rst = 1'b1;
    @(posedge sclk); #1;
    @(posedge sclk); #1;
    check_zero("R8");
    rst = 1'b0;
    sdi = 1'b0;
    s0 = strobes;
    idle(20);
    checks++;
    if (strobes != s0) begin
      errors++;
      $display("FAIL R8 partial frame survived reset: got %0d strobes expected %0d", strobes - s0, 0);
    end
    send_frame(3'h5, 8'h3C, 1'b0, 0);
    idle(5);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4 missing strobes: got %0d pending expected %0d", exp_q.size(), 0);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule